// File: doc/BRIEF.md
# Two-Level Sector Clock Selector

This block builds one clock per four-cell sector of a programmable logic array. It works from a small set of shared global clock lines. The path has two levels. First, each column has a multiplexer that picks one global line to form the column clock. The left-most column has a wider multiplexer that can also pick either of two dedicated fast clock pins. Second, each sector picks between its column clock and its own local express line. It can then invert the result or gate it off completely.

All selections come from static configuration inputs. A configuration-valid flag holds every sector clock at constant 0 until the configuration has loaded. The block is purely combinational and has no internal state. Sector `s` of column `c` drives output bit `c*SECTS_PER_COL + s`.

Top module: `clkx_sector_clock_sel`

## Requirements
- R1: For any column, a 4-bit select value `k` in 0..7 (field `col_sel_i[4*c +: 4]`) makes that column clock follow global line `gclk_i[k]`.
- R2: For any column other than column 0, select values 8..15 give a column clock of constant 0.
- R3: For column 0 (the left edge), select 8 picks `fast_clk_i[0]`, select 9 picks `fast_clk_i[1]`, and select values 10..15 give constant 0.
- R4: A sector with its source bit set to 1 takes its clock from its own express line. With the source bit at 0, it takes the clock of its column.
- R5: A sector with its enable bit at 0 drives a constant 0, whatever its invert and source settings are.
- R6: An enabled sector with its invert bit at 1 drives the complement of its selected clock. With the invert bit at 0, it drives the selected clock unchanged.
- R7: While `cfg_valid_i` is 0, every sector clock output is 0, whatever the other inputs are.
- R8: Per-sector bits `sec_src_i`, `sec_en_i`, `sec_inv_i`, `express_i` and `sec_clk_o[i]` all belong to sector `i = c*SECTS_PER_COL + s` of column `c = i / SECTS_PER_COL`.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| gclk_i | input | 8 | Shared global clock lines |
| fast_clk_i | input | 2 | Dedicated fast clock pins, reachable only from column 0 |
| cfg_valid_i | input | 1 | Configuration loaded; 0 forces all sector clocks low |
| col_sel_i | input | 4*NUM_COLS | Column clock select, 4 bits per column |
| sec_src_i | input | NSEC | Per-sector source: 1 = express line, 0 = column clock |
| sec_en_i | input | NSEC | Per-sector clock enable |
| sec_inv_i | input | NSEC | Per-sector clock inversion |
| express_i | input | NSEC | Per-sector local express lines |
| sec_clk_o | output | NSEC | Per-sector clock outputs |

## Verification
The checker watches the column clocks and the selected sector clocks on every input change. On each change it confirms four things:
- out-of-range selects produce 0,
- the source choice is correct,
- disabled or unconfigured sectors stay low, and
- inversion is applied.

Only the bench's scenarios can show that the fast pins reach column 0 and no other column. They also show that each configuration bit reaches the correct sector index (R8), and that the whole two-level path matches an independent model across swept global patterns.

// File: rtl/clkx_pkg.sv
package clkx_pkg;
  localparam int GCLK_LINES = 8;
  localparam int FAST_LINES = 2;
  localparam int SEL_W      = $clog2(GCLK_LINES + FAST_LINES);
  localparam int GIDX_W     = $clog2(GCLK_LINES);
  localparam int FIDX_W     = (FAST_LINES > 1) ? $clog2(FAST_LINES) : 1;

  // column-level choice: global lines first, then fast pins on the left edge
  function automatic logic pick_line(
    input logic [GCLK_LINES-1:0] g,
    input logic [FAST_LINES-1:0] f,
    input logic [SEL_W-1:0]      sel,
    input logic                  left_edge
  );
    logic [SEL_W-1:0] fofs;
    fofs = sel - SEL_W'(GCLK_LINES);
    if (sel < SEL_W'(GCLK_LINES))
      return g[sel[GIDX_W-1:0]];
    else if (left_edge && (fofs < SEL_W'(FAST_LINES)))
      return f[fofs[FIDX_W-1:0]];
    else
      return 1'b0;
  endfunction

  // sector-level shaping: configuration gate, enable gate, polarity
  function automatic logic shape_clk(
    input logic raw,
    input logic en,
    input logic inv,
    input logic ready
  );
    return ready & en & (raw ^ inv);
  endfunction
endpackage

// File: rtl/clkx_col_mux.sv
module clkx_col_mux
  import clkx_pkg::*;
#(
  parameter bit LEFT_EDGE = 1'b0
) (
  input  logic [GCLK_LINES-1:0] gclk_i,
  input  logic [FAST_LINES-1:0] fast_i,
  input  logic [SEL_W-1:0]      sel_i,
  output logic                  clk_o
);
  always_comb clk_o = pick_line(gclk_i, fast_i, sel_i, LEFT_EDGE);
endmodule

// File: rtl/clkx_sector_stage.sv
module clkx_sector_stage
  import clkx_pkg::*;
(
  input  logic col_clk_i,
  input  logic express_i,
  input  logic src_i,
  input  logic en_i,
  input  logic inv_i,
  input  logic ready_i,
  output logic raw_o,
  output logic clk_o
);
  always_comb begin
    raw_o = src_i ? express_i : col_clk_i;
    clk_o = shape_clk(raw_o, en_i, inv_i, ready_i);
  end
endmodule

// File: rtl/clkx_sector_clock_sel.sv
module clkx_sector_clock_sel
  import clkx_pkg::*;
#(
  parameter  int NUM_COLS      = 4,
  parameter  int SECTS_PER_COL = 4,
  localparam int NSEC          = NUM_COLS * SECTS_PER_COL
) (
  input  logic [GCLK_LINES-1:0]     gclk_i,
  input  logic [FAST_LINES-1:0]     fast_clk_i,
  input  logic                      cfg_valid_i,
  input  logic [NUM_COLS*SEL_W-1:0] col_sel_i,
  input  logic [NSEC-1:0]           sec_src_i,
  input  logic [NSEC-1:0]           sec_en_i,
  input  logic [NSEC-1:0]           sec_inv_i,
  input  logic [NSEC-1:0]           express_i,
  output logic [NSEC-1:0]           sec_clk_o
);
  // named internal events for the checker
  logic [NUM_COLS-1:0] col_clk;
  logic [NSEC-1:0]     sec_raw;

  for (genvar c = 0; c < NUM_COLS; c++) begin : g_col
    clkx_col_mux #(.LEFT_EDGE(c == 0)) u_mux (
      .gclk_i (gclk_i),
      .fast_i (fast_clk_i),
      .sel_i  (col_sel_i[c*SEL_W +: SEL_W]),
      .clk_o  (col_clk[c])
    );
    for (genvar s = 0; s < SECTS_PER_COL; s++) begin : g_sec
      localparam int IDX = c * SECTS_PER_COL + s;
      clkx_sector_stage u_stage (
        .col_clk_i (col_clk[c]),
        .express_i (express_i[IDX]),
        .src_i     (sec_src_i[IDX]),
        .en_i      (sec_en_i[IDX]),
        .inv_i     (sec_inv_i[IDX]),
        .ready_i   (cfg_valid_i),
        .raw_o     (sec_raw[IDX]),
        .clk_o     (sec_clk_o[IDX])
      );
    end
  end
endmodule

// File: rtl/clkx_sector_clock_sel_chk.sv
module clkx_sector_clock_sel_chk
  import clkx_pkg::*;
#(
  parameter  int NUM_COLS      = 4,
  parameter  int SECTS_PER_COL = 4,
  localparam int NSEC          = NUM_COLS * SECTS_PER_COL
) (
  input logic [GCLK_LINES-1:0]     gclk_i,
  input logic [FAST_LINES-1:0]     fast_clk_i,
  input logic                      cfg_valid_i,
  input logic [NUM_COLS*SEL_W-1:0] col_sel_i,
  input logic [NSEC-1:0]           sec_src_i,
  input logic [NSEC-1:0]           sec_en_i,
  input logic [NSEC-1:0]           sec_inv_i,
  input logic [NSEC-1:0]           express_i,
  input logic [NSEC-1:0]           sec_clk_o,
  input logic [NUM_COLS-1:0]       col_clk,
  input logic [NSEC-1:0]           sec_raw
);
  for (genvar c = 0; c < NUM_COLS; c++) begin : g_c
    logic [SEL_W-1:0] csel;
    assign csel = col_sel_i[c*SEL_W +: SEL_W];
    always_comb begin
      if (csel < SEL_W'(GCLK_LINES))
        AST_GLOBAL_PASS: assert (col_clk[c] == gclk_i[csel[GIDX_W-1:0]]) else $error("global line not passed"); // R1
      if (c != 0 && csel >= SEL_W'(GCLK_LINES))
        AST_INNER_HIGH_SEL_ZERO: assert (col_clk[c] == 1'b0) else $error("inner column high select not 0"); // R2
      if (c == 0 && csel >= SEL_W'(GCLK_LINES + FAST_LINES))
        AST_LEFT_HIGH_SEL_ZERO: assert (col_clk[c] == 1'b0) else $error("left column out-of-range not 0"); // R3
    end
  end

  for (genvar i = 0; i < NSEC; i++) begin : g_s
    always_comb begin
      AST_SOURCE_PICK: assert (sec_raw[i] == (sec_src_i[i] ? express_i[i] : col_clk[i / SECTS_PER_COL])) else $error("source pick"); // R4
      if (!sec_en_i[i])
        AST_DISABLED_LOW: assert (sec_clk_o[i] == 1'b0) else $error("disabled sector not low"); // R5
      if (cfg_valid_i && sec_en_i[i])
        AST_POLARITY: assert (sec_clk_o[i] == (sec_inv_i[i] ? ~sec_raw[i] : sec_raw[i])) else $error("polarity"); // R6
      if (!cfg_valid_i)
        AST_UNCONFIGURED_LOW: assert (sec_clk_o[i] == 1'b0) else $error("unconfigured sector not low"); // R7
    end
  end
endmodule

bind clkx_sector_clock_sel clkx_sector_clock_sel_chk #(
  .NUM_COLS(NUM_COLS), .SECTS_PER_COL(SECTS_PER_COL)
) u_chk (
  .gclk_i(gclk_i), .fast_clk_i(fast_clk_i), .cfg_valid_i(cfg_valid_i),
  .col_sel_i(col_sel_i), .sec_src_i(sec_src_i), .sec_en_i(sec_en_i),
  .sec_inv_i(sec_inv_i), .express_i(express_i), .sec_clk_o(sec_clk_o),
  .col_clk(col_clk), .sec_raw(sec_raw)
);

// File: tb/clkx_sector_clock_sel_test.sv
module clkx_sector_clock_sel_test;
  localparam int NC  = 4;
  localparam int SPC = 4;
  localparam int NS  = NC * SPC;

  logic clk = 1'b0;
  always #2.5 clk = ~clk;  // 200 MHz

  logic [7:0]      gclk   = '0;
  logic [1:0]      fast   = '0;
  logic            valid  = 1'b0;
  logic [NC*4-1:0] csel   = '0;
  logic [NS-1:0]   src    = '0;
  logic [NS-1:0]   en     = '0;
  logic [NS-1:0]   inv    = '0;
  logic [NS-1:0]   ex     = '0;
  logic [NS-1:0]   sclk;

  clkx_sector_clock_sel #(.NUM_COLS(NC), .SECTS_PER_COL(SPC)) uut (
    .gclk_i(gclk), .fast_clk_i(fast), .cfg_valid_i(valid), .col_sel_i(csel),
    .sec_src_i(src), .sec_en_i(en), .sec_inv_i(inv), .express_i(ex),
    .sec_clk_o(sclk)
  );

  int total = 0;
  int bad   = 0;
  bit done  = 0;

  logic [NS-1:0] exp_q[$];
  string         tag_q[$];

  // independent model of one sector
  function automatic logic model_sector(int i);
    int c;
    int k;
    logic cc;
    logic r;
    c  = i / SPC;
    k  = int'(csel[c*4 +: 4]);
    cc = 1'b0;
    if (k <= 7) cc = gclk[k];
    else if (c == 0 && k == 8) cc = fast[0];
    else if (c == 0 && k == 9) cc = fast[1];
    r = src[i] ? ex[i] : cc;
    if (!valid || !en[i]) return 1'b0;
    return inv[i] ? !r : r;
  endfunction

  task automatic drive(input string tag);
    logic [NS-1:0] e;
    for (int i = 0; i < NS; i++) e[i] = model_sector(i);
    exp_q.push_back(e);
    tag_q.push_back(tag);
  endtask

  // monitor: compare away from the edge the inputs changed on
  always @(negedge clk) begin
    if (exp_q.size() > 0) begin
      logic [NS-1:0] e;
      string t;
      e = exp_q.pop_front();
      t = tag_q.pop_front();
      total++;
      if (sclk !== e) begin
        bad++;
        $display("FAIL %s: sec_clk=%h expected=%h", t, sclk, e);
      end
    end
  end

  initial begin
    #100000;
    if (!done) begin
      bad++;
      total++;
      $display("FAIL watchdog: done=0 expected=1");
      $display("  test done: total=%0d bad=%0d", total, bad);
      $finish;
    end
  end

  initial begin
    // R7 reset / unconfigured state
    for (int v = 0; v < 4; v++) begin
      @(posedge clk); #1;
      gclk = 8'hFF; fast = 2'b11; ex = '1; en = '1; inv = (v[0]) ? '1 : '0;
      src = (v[1]) ? '1 : '0; csel = {NC{4'(v)}}; valid = 1'b0;
      drive("R7 unconfigured");
    end

    // R1 R2 R3 column selection sweep, distinct select per column
    for (int b = 0; b < 16; b++) begin
      for (int p = 0; p < 4; p++) begin
        @(posedge clk); #1;
        valid = 1'b1; src = '0; en = '1; inv = '0; ex = '0;
        gclk = (p < 2) ? 8'(1 << ((b + p) % 8)) : ~8'(1 << ((b + p) % 8));
        fast = 2'(p);
        for (int c = 0; c < NC; c++) csel[c*4 +: 4] = 4'((b + 5 * c) % 16);
        drive((b < 8) ? "R1 global select" : "R2 R3 high select");
      end
    end

    // R3 left-edge fast pins explicitly, with other columns at 8/9
    for (int k = 8; k < 10; k++) begin
      for (int p = 0; p < 4; p++) begin
        @(posedge clk); #1;
        gclk = 8'h00; fast = 2'(p); csel = {NC{4'(k)}};
        drive("R3 left fast pin");
      end
    end

    // R4 R5 R6 sector stage sweep, settings rotated across sectors
    for (int m = 0; m < 8; m++) begin
      for (int p = 0; p < 4; p++) begin
        @(posedge clk); #1;
        valid = 1'b1; fast = 2'b10;
        gclk = (p[0]) ? 8'hA5 : 8'h3C;
        ex   = (p[1]) ? 16'hF0C3 : 16'h5A69;
        for (int c = 0; c < NC; c++) csel[c*4 +: 4] = 4'((m + 3 * c + p) % 10);
        for (int i = 0; i < NS; i++) begin
          int code;
          code = (m + i) % 8;
          src[i] = code[0];
          en[i]  = code[1];
          inv[i] = code[2];
        end
        drive("R4 R5 R6 sector stage");
      end
    end

    // R8 one sector enabled at a time, inverted zero column clock
    for (int i = 0; i < NS; i++) begin
      @(posedge clk); #1;
      gclk = '0; fast = '0; csel = '0; src = '0; ex = '0; inv = '1;
      en = NS'(1) << i;
      drive("R8 sector index");
    end

    // R7 dropping configuration with everything active
    @(posedge clk); #1;
    gclk = '1; en = '1; inv = '0; valid = 1'b0;
    drive("R7 config drop");

    while (exp_q.size() > 0) @(posedge clk);
    @(posedge clk);
    done = 1;
    $display("  test done: total=%0d bad=%0d", total, bad);
    $finish;
  end
endmodule